// File: doc/BRIEF.md
# SD Host Slot Wrapper Register File

This block is the shared control and status front end that sits ahead of one or two SD host slot controllers. It decodes a 4 KB window on a 32-bit register bus that takes only whole-word transfers. Locally it keeps a slot-presence and control word, a debounce word, general read/write storage and a live interrupt status word. Each slot's capability and maximum-current values are held in per-slot registers that drive side outputs. The slots' interrupt levels are merged into one interrupt line.

A request is presented for one cycle on `req_valid`. One cycle later `rsp_ready` pulses, and read data comes with it. Writes take effect at the request edge. Addresses that fall inside a slot's own register window are not served locally. For those, the block raises that slot's select line in the request cycle so the slot controller can answer.

Top module: `sdwrap_regs`

## Requirements
- R1: After reset the control word at offset 0x000 reads 0x0001_0000, with bit 17 also set when NUM_SLOTS is 2. The debounce word at 0x004 reads 0x0000_0005. Each slot capability output equals CAP_DEFAULT. Maximum-current outputs, interrupt status, `irq`, `slot_rst` and `rsp_ready` are all zero.
- R2: A write to offset 0x000 stores the written word with bit 0 forced to 0, so bit 0 of that word never reads back as 1.
- R3: A write to offset 0x000 with data bit 0 set raises `slot_rst` for exactly the one cycle that follows the write edge.
- R4: Every local word below LOCAL_BYTES that is not otherwise assigned is plain storage and returns the last value written to it. This includes the debounce word.
- R5: Offsets 0x010 and 0x018 hold slot 0's capability and maximum-current words, and 0x020 and 0x028 hold slot 1's. Writes to these drive `slot_cap` and `slot_maxcur`, with slot i in bits [32i+31:32i], and reads return the same values.
- R6: The status word at 0x0FC has bit n equal to `slot_irq[n]` as sampled at the previous clock edge, and its other bits are zero. Writes to 0x0FC have no effect on it.
- R7: `irq` is high in the cycle after any `slot_irq` bit is high, and low in the cycle after all are low.
- R8: Outside the slot windows, reads at or beyond LOCAL_BYTES return zero and writes there change no local state.
- R9: When `req_valid` is high, `slot_sel[i]` is high in that same cycle if address bits [11:8] equal i+1, so slot 0 owns 0x100-0x1FF and slot 1 owns 0x200-0x2FF. Such an access returns zero read data and changes no local state.
- R10: `rsp_ready` is high exactly one cycle after each `req_valid`. `rsp_rdata` carries the read value in that cycle for reads and zero for writes.
- R11: The word index is address bits [11:2], so address bits [1:0] do not select a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address within the window |
| req_wdata | input | DATA_W | Write data |
| rsp_ready | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_ready |
| slot_sel | output | NUM_SLOTS | Slot window select, same cycle as the request |
| slot_cap | output | NUM_SLOTS*DATA_W | Per-slot capability words |
| slot_maxcur | output | NUM_SLOTS*DATA_W | Per-slot maximum-current words |
| slot_rst | output | 1 | One-cycle reset strobe toward the slots |
| slot_irq | input | NUM_SLOTS | Per-slot interrupt levels |
| irq | output | 1 | Merged interrupt |

## Verification
Read data, `rsp_ready` and `slot_rst` each pass through one register, so the bench samples them at the falling edge that follows the request's rising edge. `slot_sel` is decoded directly from the request, so it is sampled before the request edge. Side outputs and the status word reflect a write or an interrupt level after one edge, and the bench checks them at the next falling edge. Tests for ignored writes read back the words that could have changed, through the bus or the side outputs.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_INFO, K_PLAIN, K_STAT, K_CAP, K_MAXC, K_SLOT
  } sdw_kind_e;

  localparam int INFO_WORD  = 0;
  localparam int DEB_WORD   = 1;
  localparam int STAT_WORD  = 63;
  localparam logic [31:0] DEB_RESET = 32'h0000_0005;
  localparam int PRESENT_BIT0 = 16;

  function automatic int cap_word(input int slot);
    return 4 * (slot + 1);
  endfunction

  function automatic int maxc_word(input int slot);
    return 4 * (slot + 1) + 2;
  endfunction
endpackage

// File: rtl/sdw_addr_decode.sv
module sdw_addr_decode
  import sdw_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_SLOTS   = 2,
  parameter int LOCAL_BYTES = 256
) (
  input  logic [ADDR_W-1:0]    addr,
  output sdw_kind_e            kind,
  output logic [NUM_SLOTS-1:0] win_hit,
  output logic [NUM_SLOTS-1:0] cap_hit,
  output logic [NUM_SLOTS-1:0] max_hit
);
  localparam int SEL_W  = ADDR_W - 8;
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(LOCAL_BYTES);

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    kind    = K_NONE;
    win_hit = '0;
    cap_hit = '0;
    max_hit = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (addr[ADDR_W-1:8] == SEL_W'(i + 1)) begin
        win_hit[i] = 1'b1;
        kind       = K_SLOT;
      end
    end
    if (kind != K_SLOT && {1'b0, addr} < LIMIT) begin
      if (word == WORD_W'(INFO_WORD))      kind = K_INFO;
      else if (word == WORD_W'(STAT_WORD)) kind = K_STAT;
      else                                 kind = K_PLAIN;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (word == WORD_W'(cap_word(i))) begin
          cap_hit[i] = 1'b1;
          kind       = K_CAP;
        end
        if (word == WORD_W'(maxc_word(i))) begin
          max_hit[i] = 1'b1;
          kind       = K_MAXC;
        end
      end
    end
  end
endmodule

// File: rtl/sdw_local_regs.sv
module sdw_local_regs
  import sdw_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int WORDS     = 64,
  parameter int IDX_W     = 6,
  parameter int NUM_SLOTS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] INFO_RESET =
      (DATA_W'(1) << PRESENT_BIT0) |
      ((NUM_SLOTS == 2) ? (DATA_W'(1) << (PRESENT_BIT0 + 1)) : '0);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) begin
        if (i == INFO_WORD)     mem[i] <= INFO_RESET;
        else if (i == DEB_WORD) mem[i] <= DATA_W'(DEB_RESET);
        else                    mem[i] <= '0;
      end
    end else if (we) begin
      if (idx == IDX_W'(INFO_WORD)) mem[idx] <= wdata & ~DATA_W'(1);
      else                          mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

  // R4
  store_chk: assert property (@(posedge clk) disable iff (rst)
    (we && idx != IDX_W'(INFO_WORD)) |=> mem[$past(idx)] == $past(wdata));
endmodule

// File: rtl/sdw_slot_mirror.sv
module sdw_slot_mirror #(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] CAP_RESET = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_we,
  input  logic              max_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cap_q,
  output logic [DATA_W-1:0] max_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= DATA_W'(CAP_RESET);
      max_q <= '0;
    end else begin
      if (cap_we) cap_q <= wdata;
      if (max_we) max_q <= wdata;
    end
  end

  // R5
  cap_store_chk: assert property (@(posedge clk) disable iff (rst)
    cap_we |=> cap_q == $past(wdata));
  // R5
  max_store_chk: assert property (@(posedge clk) disable iff (rst)
    max_we |=> max_q == $past(wdata));
endmodule

// File: rtl/sdwrap_regs.sv
module sdwrap_regs
  import sdw_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          DATA_W      = 32,
  parameter int          NUM_SLOTS   = 2,
  parameter int          LOCAL_BYTES = 256,
  parameter logic [31:0] CAP_DEFAULT = 32'h01E8_0081
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rsp_ready,
  output logic [DATA_W-1:0]             rsp_rdata,
  output logic [NUM_SLOTS-1:0]          slot_sel,
  output logic [NUM_SLOTS*DATA_W-1:0]   slot_cap,
  output logic [NUM_SLOTS*DATA_W-1:0]   slot_maxcur,
  output logic                          slot_rst,
  input  logic [NUM_SLOTS-1:0]          slot_irq,
  output logic                          irq
);
  localparam int LOCAL_WORDS = LOCAL_BYTES / 4;
  localparam int LOCAL_IDX_W = $clog2(LOCAL_WORDS);

  sdw_kind_e            kind;
  logic [NUM_SLOTS-1:0] win_hit, cap_hit, max_hit;
  logic [DATA_W-1:0]    st_rdata, rd_mux;
  logic [NUM_SLOTS-1:0] irq_stat_q;
  logic                 wr_req, st_we;

  sdw_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .LOCAL_BYTES(LOCAL_BYTES)
  ) u_dec (
    .addr(req_addr), .kind(kind),
    .win_hit(win_hit), .cap_hit(cap_hit), .max_hit(max_hit)
  );

  assign wr_req = req_valid && req_write;
  assign st_we  = wr_req && (kind == K_INFO || kind == K_PLAIN);

  sdw_local_regs #(
    .DATA_W(DATA_W), .WORDS(LOCAL_WORDS), .IDX_W(LOCAL_IDX_W),
    .NUM_SLOTS(NUM_SLOTS)
  ) u_store (
    .clk(clk), .rst(rst), .we(st_we),
    .idx(req_addr[LOCAL_IDX_W+1:2]), .wdata(req_wdata), .rdata(st_rdata)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    sdw_slot_mirror #(.DATA_W(DATA_W), .CAP_RESET(CAP_DEFAULT)) u_mirror (
      .clk(clk), .rst(rst),
      .cap_we(wr_req && cap_hit[s]), .max_we(wr_req && max_hit[s]),
      .wdata(req_wdata),
      .cap_q(slot_cap[s*DATA_W +: DATA_W]),
      .max_q(slot_maxcur[s*DATA_W +: DATA_W])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (kind)
      K_INFO, K_PLAIN: rd_mux = st_rdata;
      K_STAT:          rd_mux = DATA_W'(irq_stat_q);
      K_CAP: for (int i = 0; i < NUM_SLOTS; i++)
               if (cap_hit[i]) rd_mux = slot_cap[i*DATA_W +: DATA_W];
      K_MAXC: for (int i = 0; i < NUM_SLOTS; i++)
               if (max_hit[i]) rd_mux = slot_maxcur[i*DATA_W +: DATA_W];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ready  <= 1'b0;
      rsp_rdata  <= '0;
      slot_rst   <= 1'b0;
      irq_stat_q <= '0;
    end else begin
      rsp_ready  <= req_valid;
      rsp_rdata  <= (req_valid && !req_write) ? rd_mux : '0;
      slot_rst   <= wr_req && kind == K_INFO && req_wdata[0];
      irq_stat_q <= slot_irq;
    end
  end

  assign irq      = |irq_stat_q;
  assign slot_sel = win_hit & {NUM_SLOTS{req_valid}};

  // R10
  ready_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_ready);
  // R2
  info_bit0_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && kind == K_INFO) |=> !rsp_rdata[0]);
  // R3
  rst_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    slot_rst |-> $past(wr_req && kind == K_INFO && req_wdata[0]));
  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (|slot_irq) |=> irq);
  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !(|slot_irq) |=> !irq);
  // R9
  slot_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_sel));
  // R8
  none_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && kind == K_NONE) |=> rsp_rdata == '0);
endmodule

// File: tb/sdwrap_regs_tb.sv
module sdwrap_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CAP_DEF = 32'h01E8_0081;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0,         32'h0003_0000, 4'd1},  // R1 control word
    '{1'b0, 12'h004, 32'h0,         32'h0000_0005, 4'd1},  // R1 debounce
    '{1'b0, 12'h010, 32'h0,         CAP_DEF,       4'd1},  // R1 cap slot 0
    '{1'b0, 12'h028, 32'h0,         32'h0,         4'd1},  // R1 maxcur slot 1
    '{1'b1, 12'h004, 32'h0000_0010, 32'h0,         4'd10}, // R10 write gives zero data
    '{1'b0, 12'h004, 32'h0,         32'h0000_0010, 4'd4},  // R4 debounce stored
    '{1'b1, 12'h040, 32'hA5A5_5A5A, 32'h0,         4'd4},
    '{1'b0, 12'h040, 32'h0,         32'hA5A5_5A5A, 4'd4},  // R4 plain word
    '{1'b1, 12'h000, 32'h1234_5679, 32'h0,         4'd2},
    '{1'b0, 12'h000, 32'h0,         32'h1234_5678, 4'd2},  // R2 bit 0 cleared
    '{1'b1, 12'h020, 32'hCAFE_0001, 32'h0,         4'd5},
    '{1'b0, 12'h020, 32'h0,         32'hCAFE_0001, 4'd5},  // R5 cap slot 1
    '{1'b1, 12'h0FC, 32'hFFFF_FFFF, 32'h0,         4'd6},
    '{1'b0, 12'h0FC, 32'h0,         32'h0,         4'd6},  // R6 write ignored
    '{1'b0, 12'h006, 32'h0,         32'h0000_0010, 4'd11}, // R11 low bits ignored
    '{1'b0, 12'h304, 32'h0,         32'h0,         4'd8}   // R8 beyond local
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready, slot_rst, irq;
  logic [31:0] rsp_rdata;
  logic [1:0]  slot_sel, slot_irq = 2'b00;
  logic [63:0] slot_cap, slot_maxcur;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdwrap_regs u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .slot_sel(slot_sel), .slot_cap(slot_cap),
    .slot_maxcur(slot_maxcur), .slot_rst(slot_rst), .slot_irq(slot_irq),
    .irq(irq)
  );

  task automatic check(input int r, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", r, got, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the response.
  task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d,
                        output logic rdy, output logic [31:0] rd, output logic rs);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    rdy = rsp_ready; rd = rsp_rdata; rs = slot_rst;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic rdy, rs;
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state of side outputs
    check(1, {63'd0, rsp_ready}, 64'd0);
    check(1, slot_cap, {CAP_DEF, CAP_DEF});
    check(1, slot_maxcur, 64'd0);
    check(1, {62'd0, irq, slot_rst}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].addr, VECS[i].wdata, rdy, rd, rs);
      check(10, {63'd0, rdy}, 64'd1);
      check(int'(VECS[i].req), {32'd0, rd}, {32'd0, VECS[i].exp});
    end

    // R5 side outputs follow writes
    check(5, slot_cap[63:32], 64'hCAFE_0001);
    access(1'b1, 12'h018, 32'h0000_0321, rdy, rd, rs);
    check(5, slot_maxcur, 64'h0000_0321);
    access(1'b0, 12'h018, 32'h0, rdy, rd, rs);
    check(5, rd, 64'h0000_0321);

    // R8 write beyond local space leaves debounce and plain words intact
    access(1'b1, 12'h304, 32'hDEAD_BEEF, rdy, rd, rs);
    access(1'b0, 12'h004, 32'h0, rdy, rd, rs);
    check(8, rd, 64'h0000_0010);

    // R3 reset strobe: one cycle after a write with bit 0 set
    access(1'b1, 12'h000, 32'h0000_0001, rdy, rd, rs);
    check(3, {63'd0, rs}, 64'd1);
    @(negedge clk);
    check(3, {63'd0, slot_rst}, 64'd0);
    access(1'b1, 12'h000, 32'h0000_0000, rdy, rd, rs);
    check(3, {63'd0, rs}, 64'd0);

    // R9 slot window select, zero data, no local effect
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h204; req_wdata = 32'h7777_7777;
    #1;
    check(9, {62'd0, slot_sel}, 64'd2);
    req_addr = 12'h1F0;
    #1;
    check(9, {62'd0, slot_sel}, 64'd1);
    req_valid = 1'b0;
    #1;
    check(9, {62'd0, slot_sel}, 64'd0);
    @(negedge clk);
    access(1'b1, 12'h104, 32'h9999_9999, rdy, rd, rs);
    access(1'b0, 12'h104, 32'h0, rdy, rd, rs);
    check(9, rd, 64'd0);
    access(1'b0, 12'h004, 32'h0, rdy, rd, rs);
    check(9, rd, 64'h0000_0010);

    // R6 / R7 interrupt status and merged line
    slot_irq = 2'b10;
    @(negedge clk);
    check(7, {63'd0, irq}, 64'd1);
    access(1'b0, 12'h0FC, 32'h0, rdy, rd, rs);
    check(6, rd, 64'd2);
    slot_irq = 2'b11;
    @(negedge clk);
    access(1'b0, 12'h0FC, 32'h0, rdy, rd, rs);
    check(6, rd, 64'd3);
    slot_irq = 2'b01;
    @(negedge clk);
    check(7, {63'd0, irq}, 64'd1);
    slot_irq = 2'b00;
    @(negedge clk);
    check(7, {63'd0, irq}, 64'd0);
    access(1'b0, 12'h0FC, 32'h0, rdy, rd, rs);
    check(6, rd, 64'd0);

    // R1 reset restores defaults after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    access(1'b0, 12'h000, 32'h0, rdy, rd, rs);
    check(1, rd, 64'h0003_0000);
    check(1, slot_cap, {CAP_DEF, CAP_DEF});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule